// File: doc/BRIEF.md
# E1 Receive Channel-Associated Signaling Capture

This block sits behind an external E1 framer. Each received byte arrives with its timeslot number and its frame number within the multiframe. The block records the timeslot-16 byte of every frame into a private shadow store, one entry per frame. When the last frame of a multiframe has delivered its timeslot-16 byte, the block copies all sixteen entries at once into a bank the host can read.

The host sees signaling that changes only at multiframe boundaries, so it has a full multiframe (2 ms) to read a consistent snapshot. A sticky flag tells the host that a fresh snapshot has arrived. A read strobe for the status clears it. A framer indication of lost multiframe alignment blocks the copy, so a snapshot from a misaligned multiframe never reaches the host.

Top module: `e1_cas_rx`

## Requirements
- R1: A byte is recorded only when `in_valid` is 1 and `in_ts` equals 16. Bytes in other timeslots, and timeslot-16 bytes with `in_valid` low, leave the host bank contents unchanged after the next copy.
- R2: The timeslot-16 byte of frame f (`in_frame` = f, 0..15) appears at host address f after the copy, so address 0 corresponds to signaling register 1 and address 15 to register 16.
- R3: Bytes pass unmodified, bit 7 being the first bit. Address 0 holds the multiframe alignment nibble (0000) in bits 7:4 and the spare/alarm bits in bits 3:0. Address n (1..15) holds channel n's A,B,C,D in bits 7,6,5,4 and channel n+15's A,B,C,D in bits 3,2,1,0.
- R4: The host bank changes only on the clock edge that accepts a valid timeslot-16 byte of frame 15 with `mf_lost` low. It then takes all sixteen shadow entries, frame 15's entry being the byte accepted on that same edge. `rd_data` follows `rd_addr` combinationally.
- R5: `new_sig` becomes 1 on the same edge as each copy and stays 1 until it is cleared.
- R6: A 1 on `stat_rd` clears `new_sig` at the next edge. If a copy happens on that same edge, the flag stays 1.
- R7: With `mf_lost` high when the frame-15 timeslot-16 byte is accepted, no copy happens and `new_sig` is not set. The shadow store still records bytes.
- R8: A synchronous reset (`rst` high at a clock edge) makes every bank address read 0x00 and clears `new_sig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the received byte |
| in_byte | input | 8 | Received byte, bit 7 first on the line |
| in_ts | input | 5 | Timeslot number of the byte, 0..31 |
| in_frame | input | 4 | Frame number in the multiframe, 0..15 |
| mf_lost | input | 1 | Framer reports multiframe alignment lost |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 8 | Host bank entry at `rd_addr` |
| stat_rd | input | 1 | Host status read strobe, clears the flag |
| new_sig | output | 1 | Sticky fresh-snapshot flag |

## Verification
The assertions assume that the framer presents `in_frame` and `in_ts` as coherent positions. They also assume that the host holds `rd_addr` steady when it expects a steady read. The checker needs nothing more, because it derives the copy event from the ports alone. The stimulus walks complete multiframes in timeslot order, with random byte values and random invalid gaps. It also inserts spurious invalid timeslot-16 bytes, and it moves `rd_addr` only between accepted bytes. Directed multiframes cover the lost-alignment case, a status read that coincides with a copy, and the channel nibble layout.

// File: rtl/e1_cas_rx.sv
module e1_cas_rx #(
  parameter int SIG_TS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic [4:0] in_ts,
  input  logic [3:0] in_frame,
  input  logic       mf_lost,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       stat_rd,
  output logic       new_sig
);
  localparam logic [4:0] TS = 5'(SIG_TS);

  logic [7:0] shadow [16];
  logic [7:0] bank   [16];
  logic       take, copy;

  assign take    = in_valid && (in_ts == TS);
  assign copy    = take && (in_frame == 4'd15) && !mf_lost;
  assign rd_data = bank[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) begin
        shadow[i] <= '0;
        bank[i]   <= '0;
      end
      new_sig <= 1'b0;
    end else begin
      if (take) shadow[in_frame] <= in_byte;
      if (copy) begin
        for (int i = 0; i < 15; i++) bank[i] <= shadow[i];
        bank[15] <= in_byte;
      end
      if (copy)         new_sig <= 1'b1;
      else if (stat_rd) new_sig <= 1'b0;
    end
  end
endmodule

// File: rtl/e1_cas_rx_chk.sv
module e1_cas_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic [4:0] in_ts,
  input logic [3:0] in_frame,
  input logic       mf_lost,
  input logic [3:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       stat_rd,
  input logic       new_sig
);
  logic fire;
  assign fire = in_valid && in_ts == 5'd16 && in_frame == 4'd15 && !mf_lost;

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    fire |=> new_sig);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !fire) |=> !new_sig);

  assert_no_spurious_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (!fire && !new_sig) |=> !new_sig);

  assert_bank_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !fire |=> (rd_addr != $past(rd_addr)) || $stable(rd_data));

  assert_reset_clear_R8: assert property (@(posedge clk)
    $past(rst) |-> !new_sig);
endmodule

bind e1_cas_rx e1_cas_rx_chk i_chk (.*);

// File: tb/test_e1_cas_rx.sv
module test_e1_cas_rx;
  logic clk = 0, rst = 1, in_valid = 0, mf_lost = 0, stat_rd = 0, new_sig;
  logic [7:0] in_byte = 0, rd_data;
  logic [4:0] in_ts = 0;
  logic [3:0] in_frame = 0, rd_addr = 0;
  int total = 0, bad = 0;
  logic [7:0] sh_m [16];
  logic [7:0] bk_m [16];
  bit flag_m = 0;

  always #2 clk = ~clk;

  e1_cas_rx i_e1_cas_rx (.*);

  function automatic logic [7:0] pack_ch(input logic [3:0] hi, input logic [3:0] lo);
    return {hi, lo};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", req, act, exp); end
  endtask

  task automatic step(input bit v, input logic [4:0] ts, input logic [3:0] fr,
                      input logic [7:0] b, input bit lost, input bit rd);
    bit x;
    @(negedge clk);
    in_valid = v; in_ts = ts; in_frame = fr; in_byte = b; mf_lost = lost; stat_rd = rd;
    @(posedge clk);
    x = v && ts == 16 && fr == 15 && !lost;
    if (v && ts == 16) sh_m[fr] = b;
    if (x) for (int i = 0; i < 16; i++) bk_m[i] = sh_m[i];
    if (x) flag_m = 1; else if (rd) flag_m = 0;
  endtask

  task automatic check_bank(input string req);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      in_valid = 0; stat_rd = 0; rd_addr = 4'(a);
      #1 chk(rd_data == bk_m[a], req, rd_data, bk_m[a]);
    end
  endtask

  task automatic check_flag(input string req);
    @(negedge clk); in_valid = 0; stat_rd = 0;
    #1 chk(new_sig == flag_m, req, new_sig, flag_m);
  endtask

  task automatic send_mf(input logic [7:0] pat [16], input bit lost15, input bit rd15,
                         input int stop_frame);
    for (int f = 0; f <= stop_frame; f++)
      for (int t = 0; t < 32; t++) begin
        if (t == 16 && $urandom % 4 == 0)
          step(0, 5'd16, 4'(f), 8'($urandom), 0, 0);
        if (t != 16 && $urandom % 6 == 0)
          step(0, 5'(t), 4'(f), 8'($urandom), 0, 0);
        step(t == 16 ? 1'b1 : 1'($urandom % 2), 5'(t), 4'(f),
             t == 16 ? pat[f] : 8'($urandom),
             f == 15 ? lost15 : 1'($urandom % 2), (f == 15 && t == 16) ? rd15 : 1'b0);
      end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] pat [16];
    logic [3:0] chn [31];
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin sh_m[i] = 0; bk_m[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    check_bank("R8 reset bank");
    check_flag("R8 reset flag");

    for (int i = 0; i < 16; i++) pat[i] = 8'($urandom);
    send_mf(pat, 0, 0, 15);
    check_bank("R1 R2 first snapshot");
    check_flag("R5 flag after copy");

    for (int i = 0; i < 16; i++) pat[i] = 8'($urandom);
    send_mf(pat, 0, 0, 7);
    check_bank("R4 stable mid multiframe");
    step(0, 0, 0, 0, 0, 1);
    check_flag("R6 status read clears");

    send_mf(pat, 1, 0, 15);
    check_bank("R7 no copy when lost");
    check_flag("R7 no flag when lost");

    for (int i = 0; i < 16; i++) pat[i] = 8'($urandom);
    send_mf(pat, 0, 1, 15);
    check_flag("R6 copy wins over clear");
    check_bank("R4 copy includes frame 15");

    for (int c = 1; c <= 30; c++) chn[c] = 4'($urandom);
    pat[0] = pack_ch(4'h0, 4'hB);
    for (int n = 1; n < 16; n++) pat[n] = pack_ch(chn[n], chn[n + 15]);
    send_mf(pat, 0, 0, 15);
    for (int n = 1; n < 16; n++) begin
      @(negedge clk); in_valid = 0; rd_addr = 4'(n);
      #1 chk(rd_data[7:4] == chn[n] && rd_data[3:0] == chn[n + 15], "R3 channel nibbles",
             rd_data, pack_ch(chn[n], chn[n + 15]));
    end
    @(negedge clk); rd_addr = 0;
    #1 chk(rd_data == 8'h0B, "R3 alignment byte", rd_data, 8'h0B);

    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 16; i++) pat[i] = 8'($urandom);
      send_mf(pat, 1'($urandom % 3 == 0), 1'($urandom % 2), 15);
      check_bank("R1 R2 random multiframe");
      check_flag("R5 R6 random flag");
    end

    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    for (int i = 0; i < 16; i++) begin sh_m[i] = 0; bk_m[i] = 0; end
    flag_m = 0;
    check_bank("R8 reset after traffic");
    check_flag("R8 flag after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule